// File: doc/BRIEF.md
# Paged Edge-Detecting Digital I/O Controller

This block is a byte-wide register file that a host reaches through a 4-bit offset. It controls 48 open-drain digital lines, grouped as six 8-bit ports. Writing a 1 to a port bit pulls that line low. Writing a 0 releases the line, and an external pull-up then takes it high. Reading a port returns the inverted level of its pins, taken after a two-flop synchronizer. A control register at one offset does two jobs: it selects a page, and it holds one write-lock bit per port so that software can freeze chosen outputs.

The 24 lines of ports 0 to 2 each have an edge detector. Each detector has its own polarity bit and its own enable bit. A detected edge sets a sticky status bit. The host clears a port's status by writing any value to that port's slot on the status page. The polarity registers, the enable registers and the status/clear registers all share one three-register window, and the page number decides which set appears there. A summary register shows which ports have a status bit set, and a single interrupt output is high while any status bit is set.

Top module: `edge_io_ctrl`

## Requirements
- R1: After an asynchronous reset, every internal register holds 0. All lines are released (`pin_drive_low` = 0), `irq` is 0, the summary reads 0, and the window on every page reads 0.
- R2: A write to offset p (0 to 5) sets `pin_drive_low[8p+7:8p]` to the written byte, where 1 means drive low. A read of offset p returns the bitwise inverse of `pin_in[8p+7:8p]` as seen through the two-flop synchronizer.
- R3: Offset 7 is write-only. It takes the page in bits 7:6 and port lock bits in bits 5:0, with bit p locking port p. A write to a locked port leaves its `pin_drive_low` byte unchanged. Unlocked ports still accept writes.
- R4: When the page is 1, offsets 8, 9 and 10 read and write the polarity bytes of ports 0, 1 and 2. A polarity bit of 0 selects the high-to-low edge, and 1 selects the low-to-high edge.
- R5: When the page is 2, offsets 8 to 10 read and write the enable bytes of ports 0 to 2. A status bit can set only while its enable bit is 1.
- R6: When the page is 3, offsets 8 to 10 read the status bytes of ports 0 to 2. A status bit sets when its synchronized line shows the edge chosen by its polarity bit, and it stays set until it is cleared.
- R7: When the page is 3, a write of any value to offset 8+n clears all eight status bits of port n and leaves the other ports alone. If an edge is detected in the same cycle as the clear, that bit ends up set.
- R8: Offset 6 reads port n's pending flag in bit n (n = 0 to 2), where the flag is the OR of that port's status byte. Bits 7:3 read as 0. `irq` is the OR of all status bits.
- R9: When the page is 0, window writes are ignored and window reads return 0. Offsets 7 and 11 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 48 | Sensed line levels, port p in bits 8p+7:8p |
| pin_drive_low | output | 48 | 1 pulls the matching line low, 0 releases it |
| irq | output | 1 | High while any edge status bit is set |

## Verification
The bench sweeps several pin patterns against two polarity/enable configurations and keeps its own running status for every bit. A design that swapped the two polarities, ignored an enable bit, or let status bits decay would show up as a wrong status byte. An edge is timed to land in the exact cycle of a clear write. A design that lets the clear win would read back 0 where 1 is expected. The lock sweep leaves alternate ports locked, so a lock bit mapped to the wrong port shows up on `pin_drive_low`. Page 0 writes and reserved offsets are probed, so a design that wrote through page 0 would corrupt the polarity bytes read back later.

// File: rtl/edge_io_pkg.sv
package edge_io_pkg;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned OFF_IRQ  = 6;
    localparam int unsigned OFF_CTRL = 7;
    localparam int unsigned OFF_WIN  = 8;
    localparam int unsigned PAGE_HI  = 7;
    localparam int unsigned PAGE_LO  = 6;

    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_POL  = 2'd1,
        PG_EN   = 2'd2,
        PG_STAT = 2'd3
    } page_e;
endpackage

// File: rtl/edge_io_sync.sv
module edge_io_sync #(
    parameter int unsigned WIDTH  = 48,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/edge_io_capture.sv
module edge_io_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] en,
    input  logic         clr,
    output logic [W-1:0] status
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] stat;
    } cap_t;

    cap_t c_d, c_q;
    logic [W-1:0] rise, fall, hit;

    always_comb begin
        rise     = level & ~c_q.prev;
        fall     = ~level & c_q.prev;
        hit      = en & ((pol & rise) | (~pol & fall));
        c_d.prev = level;
        // a clear and a fresh edge in one cycle: the edge survives
        c_d.stat = (clr ? '0 : c_q.stat) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign status = c_q.stat;
endmodule

// File: rtl/edge_io_ctrl.sv
module edge_io_ctrl
    import edge_io_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = 6,
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned EDGE_PORTS  = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [PORT_W-1:0]           bus_wdata,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_drive_low,
    output logic                        irq
);
    localparam int unsigned LINES = NUM_PORTS * PORT_W;

    typedef struct packed {
        logic [NUM_PORTS-1:0][PORT_W-1:0]  outp;
        page_e                             page;
        logic [NUM_PORTS-1:0]              lock;
        logic [EDGE_PORTS-1:0][PORT_W-1:0] pol;
        logic [EDGE_PORTS-1:0][PORT_W-1:0] en;
    } regs_t;

    regs_t                             r_d, r_q;
    logic [LINES-1:0]                  lvl;
    logic [EDGE_PORTS-1:0]             wipe;
    logic [EDGE_PORTS-1:0]             pend;
    logic [EDGE_PORTS-1:0][PORT_W-1:0] stat;

    edge_io_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl)
    );

    generate
        for (genvar g = 0; g < EDGE_PORTS; g++) begin : g_edge
            edge_io_capture #(
                .W (PORT_W)
            ) u_cap (
                .clk    (clk),
                .rst_n  (rst_n),
                .level  (lvl[g*PORT_W +: PORT_W]),
                .pol    (r_q.pol[g]),
                .en     (r_q.en[g]),
                .clr    (wipe[g]),
                .status (stat[g])
            );
            assign pend[g] = |stat[g];
        end
    endgenerate

    // next-state: port outputs, page/lock, window registers, clear pulses
    always_comb begin
        r_d  = r_q;
        wipe = '0;
        if (bus_wr) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bus_addr == ADDR_W'(p) && !r_q.lock[p]) begin
                    r_d.outp[p] = bus_wdata;
                end
            end
            if (bus_addr == ADDR_W'(OFF_CTRL)) begin
                r_d.page = page_e'(bus_wdata[PAGE_HI:PAGE_LO]);
                r_d.lock = bus_wdata[NUM_PORTS-1:0];
            end
            for (int w = 0; w < EDGE_PORTS; w++) begin
                if (bus_addr == ADDR_W'(OFF_WIN + w)) begin
                    case (r_q.page)
                        PG_POL:  r_d.pol[w] = bus_wdata;
                        PG_EN:   r_d.en[w]  = bus_wdata;
                        PG_STAT: wipe[w]    = 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == ADDR_W'(p)) begin
                bus_rdata = ~lvl[p*PORT_W +: PORT_W];
            end
        end
        if (bus_addr == ADDR_W'(OFF_IRQ)) begin
            bus_rdata = PORT_W'(pend);
        end
        for (int w = 0; w < EDGE_PORTS; w++) begin
            if (bus_addr == ADDR_W'(OFF_WIN + w)) begin
                case (r_q.page)
                    PG_POL:  bus_rdata = r_q.pol[w];
                    PG_EN:   bus_rdata = r_q.en[w];
                    PG_STAT: bus_rdata = stat[w];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    assign pin_drive_low = r_q.outp;
    assign irq           = |pend;
endmodule

// File: rtl/edge_io_chk.sv
module edge_io_chk #(
    parameter int unsigned NUM_PORTS  = 6,
    parameter int unsigned PORT_W     = 8,
    parameter int unsigned EDGE_PORTS = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [3:0]                   bus_addr,
    input logic                         bus_wr,
    input logic [PORT_W-1:0]            bus_rdata,
    input logic [NUM_PORTS*PORT_W-1:0]  pin_drive_low,
    input logic                         irq,
    input logic [NUM_PORTS-1:0]         lock,
    input logic [1:0]                   page,
    input logic [EDGE_PORTS*PORT_W-1:0] pol,
    input logic [EDGE_PORTS*PORT_W-1:0] en,
    input logic [EDGE_PORTS*PORT_W-1:0] stat,
    input logic [EDGE_PORTS-1:0]        wipe
);
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assert_locked_port_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == 4'(p) && lock[p])
                |=> $stable(pin_drive_low[p*PORT_W +: PORT_W]));
        end
        for (genvar w = 0; w < EDGE_PORTS; w++) begin : g_edge
            assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !wipe[w] |=> ((stat[w*PORT_W +: PORT_W] & $past(stat[w*PORT_W +: PORT_W]))
                              == $past(stat[w*PORT_W +: PORT_W])));
            assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (stat[w*PORT_W +: PORT_W] == '0 && en[w*PORT_W +: PORT_W] == '0)
                |=> stat[w*PORT_W +: PORT_W] == '0);
            assert_wipe_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (wipe[w] && en[w*PORT_W +: PORT_W] == '0)
                |=> stat[w*PORT_W +: PORT_W] == '0);
            assert_summary_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_addr == 4'd6) |-> (bus_rdata[w] == (stat[w*PORT_W +: PORT_W] != '0)));
        end
    endgenerate

    assert_summary_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'd6) |-> (bus_rdata[PORT_W-1:EDGE_PORTS] == '0));

    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |-> !irq);

    assert_page0_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= 4'd8 && page == 2'd0) |=> ($stable(pol) && $stable(en)));
endmodule

bind edge_io_ctrl edge_io_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rdata     (bus_rdata),
    .pin_drive_low (pin_drive_low),
    .irq           (irq),
    .lock          (r_q.lock),
    .page          (r_q.page),
    .pol           (r_q.pol),
    .en            (r_q.en),
    .stat          (stat),
    .wipe          (wipe)
);

// File: tb/edge_io_ctrl_tb.sv
`timescale 1ns/1ps
module edge_io_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] pin_bus = '1;
    logic [47:0] drv;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    edge_io_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (addr),
        .bus_wr        (wr),
        .bus_wdata     (wdata),
        .bus_rdata     (rdata),
        .pin_in        (pin_bus),
        .pin_drive_low (drv),
        .irq           (irq)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  v;
        logic [7:0]  pol_m [3];
        logic [7:0]  en_m  [3];
        logic [7:0]  acc   [3];
        logic [23:0] old_l, new_l;
        logic [47:0] exp_drv;
        logic [5:0]  lk;

        settle(3);
        rst_n = 1'b1;
        settle(3);

        // R1: reset state
        check("R1 drive", drv, 48'h0);
        check("R1 irq", {47'h0, irq}, 48'h0);
        rd_reg(4'd6, v);  check("R1 summary", {40'h0, v}, 48'h0);
        rd_reg(4'd8, v);  check("R1 page0 window", {40'h0, v}, 48'h0);
        wr_reg(4'd7, 8'h40);
        for (int w = 0; w < 3; w++) begin
            rd_reg(4'(8 + w), v); check("R1 pol reset", {40'h0, v}, 48'h0);
        end
        wr_reg(4'd7, 8'h80);
        for (int w = 0; w < 3; w++) begin
            rd_reg(4'(8 + w), v); check("R1 en reset", {40'h0, v}, 48'h0);
        end
        wr_reg(4'd7, 8'h00);

        // R2: output writes and inverted input reads
        exp_drv = '0;
        for (int p = 0; p < 6; p++) begin
            v = 8'((p * 37 + 5) & 255);
            wr_reg(4'(p), v);
            exp_drv[p*8 +: 8] = v;
            check("R2 drive byte", drv, exp_drv);
        end
        for (int k = 0; k < 4; k++) begin
            pin_bus = 48'(48'h123456789ABC * (k + 1)) ^ {12{4'(k)}};
            settle(3);
            for (int p = 0; p < 6; p++) begin
                rd_reg(4'(p), v);
                check("R2 inverted read", {40'h0, v}, {40'h0, ~pin_bus[p*8 +: 8]});
            end
        end

        // R3: write locks
        lk = 6'b101010;
        wr_reg(4'd7, {2'b00, lk});
        for (int p = 0; p < 6; p++) begin
            v = 8'(8'hC3 ^ p);
            wr_reg(4'(p), v);
            if (!lk[p]) exp_drv[p*8 +: 8] = v;
        end
        check("R3 locked ports kept", drv, exp_drv);
        wr_reg(4'd7, 8'h00);
        wr_reg(4'd1, 8'h99);
        exp_drv[15:8] = 8'h99;
        check("R3 unlock restores writes", drv, exp_drv);

        // R4 R5 R6 R7 R8: edge capture sweep
        for (int cfg = 0; cfg < 2; cfg++) begin
            wr_reg(4'd7, 8'h40);
            for (int w = 0; w < 3; w++) begin
                pol_m[w] = 8'(8'h5A ^ (w * 8'h33) ^ (cfg * 8'hFF));
                wr_reg(4'(8 + w), pol_m[w]);
            end
            for (int w = 0; w < 3; w++) begin
                rd_reg(4'(8 + w), v); check("R4 pol readback", {40'h0, v}, {40'h0, pol_m[w]});
            end
            wr_reg(4'd7, 8'h80);
            for (int w = 0; w < 3; w++) begin
                en_m[w] = 8'(8'hF0 ^ (w * 8'h1D) ^ (cfg * 8'h66));
                wr_reg(4'(8 + w), en_m[w]);
            end
            for (int w = 0; w < 3; w++) begin
                rd_reg(4'(8 + w), v); check("R5 en readback", {40'h0, v}, {40'h0, en_m[w]});
            end
            wr_reg(4'd7, 8'hC0);
            for (int w = 0; w < 3; w++) begin
                wr_reg(4'(8 + w), 8'h00);
                acc[w] = '0;
            end
            rd_reg(4'd6, v); check("R8 summary after clear", {40'h0, v}, 48'h0);
            check("R8 irq after clear", {47'h0, irq}, 48'h0);
            for (int k = 0; k < 6; k++) begin
                old_l = pin_bus[23:0];
                new_l = 24'((k + 1) * 24'h9E3779) ^ 24'(cfg * 24'h5555AA);
                pin_bus[23:0] = new_l;
                settle(4);
                for (int w = 0; w < 3; w++) begin
                    acc[w] = acc[w] | (en_m[w] &
                        ((pol_m[w] & new_l[w*8 +: 8] & ~old_l[w*8 +: 8]) |
                         (~pol_m[w] & ~new_l[w*8 +: 8] & old_l[w*8 +: 8])));
                    rd_reg(4'(8 + w), v);
                    check("R6 status", {40'h0, v}, {40'h0, acc[w]});
                end
                rd_reg(4'd6, v);
                check("R8 summary", {40'h0, v},
                      {45'h0, acc[2] != 0, acc[1] != 0, acc[0] != 0});
                check("R8 irq", {47'h0, irq},
                      {47'h0, (acc[0] | acc[1] | acc[2]) != 0});
            end
            wr_reg(4'd9, 8'h5A);
            acc[1] = '0;
            for (int w = 0; w < 3; w++) begin
                rd_reg(4'(8 + w), v);
                check("R7 clear one port only", {40'h0, v}, {40'h0, acc[w]});
            end
        end

        // R7: edge in the same cycle as a clear
        wr_reg(4'd7, 8'h40); wr_reg(4'd8, 8'hFF);
        wr_reg(4'd7, 8'h80); wr_reg(4'd8, 8'hFF);
        pin_bus[7:0] = 8'h00;
        settle(4);
        wr_reg(4'd7, 8'hC0);
        wr_reg(4'd8, 8'h00);
        rd_reg(4'd8, v); check("R7 cleared", {40'h0, v}, 48'h0);
        @(negedge clk);
        #1 pin_bus[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 4'd8; wdata = 8'h00; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        settle(2);
        rd_reg(4'd8, v); check("R7 edge beats clear", {40'h0, v}, 48'h01);
        wr_reg(4'd8, 8'h00);
        rd_reg(4'd8, v); check("R7 plain clear", {40'h0, v}, 48'h0);

        // R9: page 0 window and reserved offsets
        wr_reg(4'd7, 8'h40); wr_reg(4'd9, 8'h3C);
        wr_reg(4'd7, 8'h00); wr_reg(4'd9, 8'h77);
        rd_reg(4'd9, v); check("R9 page0 read", {40'h0, v}, 48'h0);
        wr_reg(4'd7, 8'h40);
        rd_reg(4'd9, v); check("R9 page0 write ignored", {40'h0, v}, 48'h3C);
        rd_reg(4'd7, v); check("R9 ctrl reads zero", {40'h0, v}, 48'h0);
        for (int a = 11; a < 16; a++) begin
            rd_reg(4'(a), v); check("R9 reserved offset", {40'h0, v}, 48'h0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule